// File: doc/BRIEF.md
# Multicast Buffer Release Tracker

This block decides when a frame buffer handle may go back to the free pool. When a transmit job is queued, the block stores an 8-bit destination mask for that handle. A unicast job has one bit set and a multicast job has several. Each destination port raises a release request once it has read the frame's end-of-frame. A granted request clears that port's bit. The queue manager may also drop a frame. A selective drop clears only the named destination bits. A global drop clears the whole mask at once.

A handle is freed at the moment its mask goes from non-empty to empty, and never at any other time. The freed handle is pushed into a free-handle FIFO. The buffer allocator pops handles from that FIFO through a valid/ready pair. The port requests are arbitrated round-robin, and at most one handle is freed per cycle.

Top module: `mc_release_tracker`

## Requirements
- R1: After reset, `free_valid`, `rel_err` and `rel_grant` are all 0. An enqueue writes `enq_dest` as the handle's mask, and bit i of the mask stands for port i. An enqueue overrides any other update to the same handle in the same cycle.
- R2: Each cycle, at most one port's request is granted through `rel_grant` (bit i is port i). Only a port with `rel_valid` set can be granted. The search starts at the port after the last granted port, and port 0 has first priority after reset. A port holds its request until it is granted.
- R3: A granted release whose port bit is set in the handle's mask clears that bit. If this empties a unicast mask, the handle is freed.
- R4: A multicast handle is freed only after the last of its destination bits has been cleared.
- R5: A selective drop clears the bits set in `drop_dests` and nothing else. The handle stays allocated while any bit remains set, and it is freed when the drop empties the mask.
- R6: A global drop (`drop_global`=1) empties the mask of an allocated handle and frees the handle in the same cycle.
- R7: A granted release and a selective drop that target the same handle in one cycle are both applied, and the handle is freed at most once.
- R8: A granted release whose port bit is already clear changes no mask and frees nothing. It pulses `rel_err` for one cycle, starting one cycle after the grant.
- R9: At most one handle is freed per cycle. In a cycle where a drop frees a handle, any release that targets a different handle is not granted and waits for a later cycle.
- R10: Freed handles leave on `free_handle` in the order they were freed. The first one appears one cycle after it is freed. The output stays stable while `free_valid` is high and `free_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Load a destination mask for a handle |
| enq_handle | input | HW (6) | Handle being enqueued |
| enq_dest | input | NUM_PORTS (8) | Destination mask, bit i = port i |
| rel_valid | input | NUM_PORTS (8) | Per-port release request (end-of-frame read) |
| rel_handle | input | NUM_PORTS*HW (48) | Per-port handle, port i at bits [i*HW +: HW] |
| rel_grant | output | NUM_PORTS (8) | One-hot grant of a release request |
| drop_valid | input | 1 | Drop command valid |
| drop_handle | input | HW (6) | Handle being dropped |
| drop_dests | input | NUM_PORTS (8) | Destinations removed by a selective drop |
| drop_global | input | 1 | 1 = drop at every destination |
| free_valid | output | 1 | A freed handle is available |
| free_handle | output | HW (6) | Freed handle |
| free_ready | input | 1 | The allocator takes the freed handle |
| rel_err | output | 1 | Release for a destination bit that was already clear |

## Verification
The embedded properties assume three things about the inputs. An enqueue names only an idle handle. A drop names only a handle whose mask is non-empty. An enqueue never targets a handle that a drop or release hits in the same cycle. The stimulus follows these rules by construction. It enqueues only handles that it has taken back from the free output. It drops only handles whose mask in the reference model is non-zero. A handle leaves the owned pool before it can be dropped, so the two never meet. Stale requests are still allowed on purpose, for example a release for a handle that has already been dropped. These exercise the error path, and the properties exclude them explicitly.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    FS_NONE = 2'd0,
    FS_REL  = 2'd1,
    FS_DROP = 2'd2
  } free_src_e;
endpackage

// File: rtl/rt_rr_arbiter.sv
module rt_rr_arbiter #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  input  logic           hold,
  output logic [N-1:0]   grant,
  output logic [$clog2(N)-1:0] cand_idx,
  output logic           cand_any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;
  logic [N-1:0]  cand;
  int            idx;

  // rotate: search begins one past the most recent winner
  always_comb begin
    cand     = '0;
    cand_idx = '0;
    cand_any = 1'b0;
    idx      = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!cand_any && req[idx]) begin
        cand_any      = 1'b1;
        cand[idx]     = 1'b1;
        cand_idx      = IW'(idx);
      end
    end
  end

  assign grant = (cand_any && !hold) ? cand : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IW'(N - 1);
    end else if (|grant) begin
      last_q <= cand_idx;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  a_r2_only_requesters: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  a_r2_waits_while_held: assert property (@(posedge clk) disable iff (rst)
    hold |-> grant == '0);
endmodule

// File: rtl/rt_free_fifo.sv
module rt_free_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          pop, load;

  assign pop  = out_valid && ready;
  assign load = (cnt != '0) && (!out_valid || pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (load) begin
        rd_ptr    <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        out_valid <= 1'b1;
      end else if (pop) begin
        out_valid <= 1'b0;
      end
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(load);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> cnt < (AW+1)'(DEPTH));
  a_r10_hold_output: assert property (@(posedge clk) disable iff (rst)
    out_valid && !ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/rt_mask_table.sv
module rt_mask_table
  import rt_pkg::*;
#(
  parameter int P = 8,
  parameter int H = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enq_valid,
  input  logic [$clog2(H)-1:0]   enq_handle,
  input  logic [P-1:0]           enq_dest,
  input  logic                   rel_valid,
  input  logic [$clog2(H)-1:0]   rel_handle,
  input  logic [$clog2(P)-1:0]   rel_port,
  input  logic                   drop_valid,
  input  logic [$clog2(H)-1:0]   drop_handle,
  input  logic [P-1:0]           drop_dests,
  input  logic                   drop_global,
  output logic                   rel_bit,
  output logic                   drop_frees_alone,
  output logic                   free_push,
  output logic [$clog2(H)-1:0]   free_handle
);
  localparam int HW = $clog2(H);

  logic [P-1:0] mask_q [H];
  logic [P-1:0] rel_old, drop_old, rel_new, drop_new, rel_onehot, drop_rest;
  logic         same, rel_clr;
  free_src_e    src;

  always_comb begin
    rel_old    = mask_q[rel_handle];
    drop_old   = mask_q[drop_handle];
    rel_onehot = P'(1) << rel_port;
    rel_bit    = |(rel_old & rel_onehot);
    same       = (rel_handle == drop_handle);
    rel_clr    = rel_valid && rel_bit;
    rel_new    = rel_old & ~rel_onehot;
    drop_rest  = drop_old & ~drop_dests;
    drop_new   = drop_global ? '0 : drop_rest;
    if (rel_clr && same) drop_new = drop_new & ~rel_onehot;
    drop_frees_alone = drop_valid && (drop_old != '0) &&
                       (drop_global || (drop_rest == '0));
    if (drop_valid && (drop_old != '0) && (drop_new == '0))
      src = FS_DROP;
    else if (rel_clr && !(drop_valid && same) && (rel_new == '0))
      src = FS_REL;
    else
      src = FS_NONE;
    free_push   = (src != FS_NONE);
    free_handle = (src == FS_DROP) ? drop_handle : rel_handle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < H; h++) mask_q[h] <= '0;
    end else begin
      if (rel_clr && !(drop_valid && same)) mask_q[rel_handle] <= rel_new;
      if (drop_valid) mask_q[drop_handle] <= drop_new;
      if (enq_valid) mask_q[enq_handle] <= enq_dest;
    end
  end

  a_r1_enq_loads: assert property (@(posedge clk) disable iff (rst)
    enq_valid |=> mask_q[$past(enq_handle)] == $past(enq_dest));
  a_r3_release_clears: assert property (@(posedge clk) disable iff (rst)
    rel_valid && rel_bit && !(enq_valid && enq_handle == rel_handle)
    |=> (mask_q[$past(rel_handle)] & $past(rel_onehot)) == '0);
  a_r6_global_empties: assert property (@(posedge clk) disable iff (rst)
    drop_valid && drop_global && !(enq_valid && enq_handle == drop_handle)
    |=> mask_q[$past(drop_handle)] == '0);
  a_r8_miss_keeps_mask: assert property (@(posedge clk) disable iff (rst)
    rel_valid && !rel_bit && !(drop_valid && same) &&
    !(enq_valid && enq_handle == rel_handle)
    |=> mask_q[$past(rel_handle)] == $past(rel_old));
  a_r5_selective_keeps_alive: assert property (@(posedge clk) disable iff (rst)
    drop_valid && !drop_global && (drop_rest != '0) && !(rel_valid && same)
    |-> !(free_push && free_handle == drop_handle));
  a_r4_free_only_when_set: assert property (@(posedge clk) disable iff (rst)
    free_push |-> mask_q[free_handle] != '0);
endmodule

// File: rtl/mc_release_tracker.sv
module mc_release_tracker #(
  parameter int NUM_PORTS   = 8,
  parameter int NUM_HANDLES = 64,
  parameter int HW          = $clog2(NUM_HANDLES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enq_valid,
  input  logic [HW-1:0]           enq_handle,
  input  logic [NUM_PORTS-1:0]    enq_dest,
  input  logic [NUM_PORTS-1:0]    rel_valid,
  input  logic [NUM_PORTS*HW-1:0] rel_handle,
  output logic [NUM_PORTS-1:0]    rel_grant,
  input  logic                    drop_valid,
  input  logic [HW-1:0]           drop_handle,
  input  logic [NUM_PORTS-1:0]    drop_dests,
  input  logic                    drop_global,
  output logic                    free_valid,
  output logic [HW-1:0]           free_handle,
  input  logic                    free_ready,
  output logic                    rel_err
);
  localparam int PW = $clog2(NUM_PORTS);

  logic [PW-1:0] cand_idx;
  logic          cand_any, stall, granted, rel_bit, drop_frees_alone;
  logic          push;
  logic [HW-1:0] win_handle, push_handle;

  assign win_handle = rel_handle[cand_idx*HW +: HW];
  // serialize frees: a freeing drop blocks a release on another handle
  assign stall   = drop_frees_alone && cand_any && (win_handle != drop_handle);
  assign granted = |rel_grant;

  rt_rr_arbiter #(.N(NUM_PORTS)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (rel_valid),
    .hold     (stall),
    .grant    (rel_grant),
    .cand_idx (cand_idx),
    .cand_any (cand_any)
  );

  rt_mask_table #(.P(NUM_PORTS), .H(NUM_HANDLES)) u_tab (
    .clk              (clk),
    .rst              (rst),
    .enq_valid        (enq_valid),
    .enq_handle       (enq_handle),
    .enq_dest         (enq_dest),
    .rel_valid        (granted),
    .rel_handle       (win_handle),
    .rel_port         (cand_idx),
    .drop_valid       (drop_valid),
    .drop_handle      (drop_handle),
    .drop_dests       (drop_dests),
    .drop_global      (drop_global),
    .rel_bit          (rel_bit),
    .drop_frees_alone (drop_frees_alone),
    .free_push        (push),
    .free_handle      (push_handle)
  );

  rt_free_fifo #(.DEPTH(NUM_HANDLES), .W(HW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_handle),
    .ready     (free_ready),
    .out_valid (free_valid),
    .out_data  (free_handle)
  );

  always_ff @(posedge clk) begin
    if (rst) rel_err <= 1'b0;
    else     rel_err <= granted && !rel_bit;
  end

  a_r8_err_needs_request: assert property (@(posedge clk) disable iff (rst)
    rel_err |-> $past(|rel_valid));
  a_r9_no_grant_beside_drop_free: assert property (@(posedge clk) disable iff (rst)
    push && drop_valid && push_handle == drop_handle && granted
    |-> win_handle == drop_handle);
endmodule

// File: tb/sim_mc_release_tracker.sv
module sim_mc_release_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 8;
  localparam int NH = 64;
  localparam int HW = 6;
  localparam int ALL = (1 << P) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq_valid = 1'b0;
  logic [HW-1:0] enq_handle = '0;
  logic [P-1:0] enq_dest = '0;
  logic [P-1:0] rel_valid = '0;
  logic [P*HW-1:0] rel_handle = '0;
  logic [P-1:0] rel_grant;
  logic drop_valid = 1'b0;
  logic [HW-1:0] drop_handle = '0;
  logic [P-1:0] drop_dests = '0;
  logic drop_global = 1'b0;
  logic free_valid;
  logic [HW-1:0] free_handle;
  logic free_ready = 1'b1;
  logic rel_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_release_tracker #(.NUM_PORTS(P), .NUM_HANDLES(NH)) u0 (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_handle(enq_handle),
    .enq_dest(enq_dest), .rel_valid(rel_valid), .rel_handle(rel_handle),
    .rel_grant(rel_grant), .drop_valid(drop_valid), .drop_handle(drop_handle),
    .drop_dests(drop_dests), .drop_global(drop_global), .free_valid(free_valid),
    .free_handle(free_handle), .free_ready(free_ready), .rel_err(rel_err)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  // reference model state
  int mmask [NH];
  int last_port;
  int fq [$];
  bit mv;
  int mh;
  bit merr;
  int gnt;
  bit req_v [P];
  int req_h [P];
  int pool [$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_grant();
    int cand, wh, dm;
    bit dfree;
    cand = -1;
    for (int k = 1; k <= P; k++) begin
      int idx;
      idx = (last_port + k) % P;
      if (cand < 0 && req_v[idx]) cand = idx;
    end
    dm = int'(drop_dests);
    dfree = drop_valid && mmask[drop_handle] != 0 &&
            (drop_global || (mmask[drop_handle] & ~dm & ALL) == 0);
    wh = (cand >= 0) ? req_h[cand] : 0;
    gnt = (cand >= 0 && !(dfree && wh != int'(drop_handle))) ? cand : -1;
  endfunction

  function automatic void model_step();
    int wh, dh, bitv, oldw, oldd, neww, newd, freed;
    bit hit, same, popped;
    dh = int'(drop_handle);
    wh = (gnt >= 0) ? req_h[gnt] : 0;
    bitv = (gnt >= 0) ? (1 << gnt) : 0;
    oldw = mmask[wh];
    oldd = mmask[dh];
    hit = (gnt >= 0) && ((oldw & bitv) != 0);
    same = (wh == dh);
    neww = oldw & ~bitv;
    newd = drop_global ? 0 : (oldd & ~int'(drop_dests));
    if (hit && same) newd = newd & ~bitv;
    freed = -1;
    if (drop_valid && oldd != 0 && newd == 0) freed = dh;
    else if (hit && !(drop_valid && same) && neww == 0) freed = wh;
    if (hit && !(drop_valid && same)) mmask[wh] = neww;
    if (drop_valid) mmask[dh] = newd;
    if (enq_valid) mmask[enq_handle] = int'(enq_dest);
    popped = mv && free_ready;
    if (popped) pool.push_back(mh);
    if (fq.size() > 0 && (!mv || popped)) begin
      mh = fq.pop_front();
      mv = 1'b1;
    end else if (popped) begin
      mv = 1'b0;
    end
    if (freed >= 0) fq.push_back(freed);
    merr = (gnt >= 0) && !hit;
    if (gnt >= 0) begin
      last_port = gnt;
      req_v[gnt] = 1'b0;
    end
  endfunction

  task automatic cycle();
    for (int p = 0; p < P; p++) begin
      rel_valid[p] = req_v[p];
      rel_handle[p*HW +: HW] = HW'(req_h[p]);
    end
    #1;
    model_grant();
    chk("R2", "rel_grant", int'(rel_grant), (gnt >= 0) ? (1 << gnt) : 0);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "free_valid", int'(free_valid), int'(mv));
    if (mv) chk(tag, "free_handle", int'(free_handle), mh);
    chk("R8", "rel_err", int'(rel_err), int'(merr));
    enq_valid = 1'b0;
    drop_valid = 1'b0;
    drop_global = 1'b0;
  endtask

  task automatic enq(int h, int m);
    enq_valid = 1'b1;
    enq_handle = HW'(h);
    enq_dest = P'(m);
    for (int i = 0; i < pool.size(); i++)
      if (pool[i] == h) begin pool.delete(i); break; end
  endtask

  task automatic drop(int h, int m, bit g);
    drop_valid = 1'b1;
    drop_handle = HW'(h);
    drop_dests = P'(m);
    drop_global = g;
  endtask

  task automatic post(int p, int h);
    req_v[p] = 1'b1;
    req_h[p] = h;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    for (int h = 0; h < NH; h++) begin mmask[h] = 0; pool.push_back(h); end
    for (int p = 0; p < P; p++) begin req_v[p] = 1'b0; req_h[p] = 0; end
    last_port = P - 1; mv = 1'b0; mh = 0; merr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    chk("R1", "reset free_valid", int'(free_valid), 0);
    chk("R1", "reset rel_err", int'(rel_err), 0);
    chk("R1", "reset rel_grant", int'(rel_grant), 0);

    tag = "R3";                       // unicast: one destination bit
    enq(5, 8'h04); cycle();
    post(2, 5); settle(3);

    tag = "R4";                       // multicast 0,3,6
    enq(7, 8'h49); cycle();
    post(3, 7); cycle();
    chk("R4", "not freed early", int'(free_valid), 0);
    post(0, 7); settle(2);
    chk("R4", "still held", int'(free_valid), 0);
    post(6, 7); settle(3);

    tag = "R2";                       // all ports contend for one handle
    enq(10, 8'hFF); cycle();
    for (int p = 0; p < P; p++) post(p, 10);
    settle(11);

    tag = "R5";                       // selective drop keeps the handle
    enq(12, 8'h0F); cycle();
    drop(12, 8'h03, 1'b0); cycle();
    chk("R5", "selective no free", int'(free_valid), 0);
    post(2, 12); cycle();
    drop(12, 8'h08, 1'b0); settle(3);

    tag = "R6";                       // global drop, then stale release
    enq(20, 8'h30); cycle();
    drop(20, 8'h00, 1'b1); settle(2);
    tag = "R8";
    post(4, 20); settle(3);
    post(1, 30); settle(2);

    tag = "R7";                       // release and selective drop meet
    enq(22, 8'h03); cycle();
    post(0, 22); drop(22, 8'h02, 1'b0); settle(3);

    tag = "R9";                       // drop frees one, release waits
    enq(40, 8'h01); cycle();
    enq(41, 8'h02); cycle();
    post(1, 41); drop(40, 8'h00, 1'b1); cycle();
    chk("R9", "release held off", int'(req_v[1]), 1);
    settle(4);

    tag = "R10";                      // backpressure and ordering
    free_ready = 1'b0;
    enq(50, 8'h01); cycle();
    enq(51, 8'h01); cycle();
    enq(52, 8'h01); cycle();
    post(0, 50); cycle(); post(0, 51); cycle(); post(0, 52); settle(4);
    free_ready = 1'b1;
    settle(5);

    tag = "R4";                       // mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      free_ready = ($urandom_range(0, 9) < 8);
      for (int p = 0; p < P; p++) begin
        if (!req_v[p] && $urandom_range(0, 9) < 3) begin
          int start;
          start = $urandom_range(0, NH - 1);
          for (int k = 0; k < NH; k++) begin
            int h;
            h = (start + k) % NH;
            if ((mmask[h] >> p) & 1) begin post(p, h); break; end
          end
          if (!req_v[p] && $urandom_range(0, 19) == 0) post(p, start);
        end
      end
      if (pool.size() > 0 && $urandom_range(0, 9) < 3) begin
        int h, m;
        h = pool[$urandom_range(0, pool.size() - 1)];
        m = $urandom_range(1, ALL);
        enq(h, m);
      end
      if ($urandom_range(0, 9) == 0) begin
        int start;
        start = $urandom_range(0, NH - 1);
        for (int k = 0; k < NH; k++) begin
          int h;
          h = (start + k) % NH;
          if (mmask[h] != 0 && !(enq_valid && int'(enq_handle) == h)) begin
            drop(h, $urandom_range(0, ALL), $urandom_range(0, 6) == 0);
            break;
          end
        end
      end
      cycle();
    end
    free_ready = 1'b1;
    for (int p = 0; p < P; p++) req_v[p] = 1'b0;
    settle(NH + 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule